// File: doc/BRIEF.md
# DAC Power-State and Reset Controller

This block decides when the digital core of a voltage-output DAC is asleep and when it is awake, and it produces the reset-value load for the converter's two data registers. Asynchronous board pins are first passed through synchronizers. These are a power-down request, a lockout that forbids power-down, an active-low clear and a reset-value strap. Decoded serial commands arrive as single-cycle pulses from the command decoder. The block drives a shutdown flag, a high-impedance enable for the analog output stage, a one-cycle load strobe with the reset code, a reset pulse for the user-programmable output bit, and a flag that stays high while the voltage reference settles.

Shutdown can be entered from the pin or by command, and only while the lockout input is high. Releasing the power-down pin never ends shutdown. Only three events end it: a falling lockout, an asserted clear, or a wake command. A wake command is either a load-both or an update-from-input command. Entry and exit never touch register data. Only power-up and clear issue a load strobe. After every wake, and after reset, a counter holds the settle flag for a number of cycles. A parameter picks the internal-reference or the external-reference count.

Top module: `dac_pwr_ctrl`

## Requirements
- R1: During reset and after it, `shdn` is 0. In the cycle after the first clock edge following reset release, `rv_load` pulses for one cycle. While it pulses, `rv_code` is 12'h800 if `rstval_pin` is 1 and 12'h000 if it is 0. `settle_busy` is high during reset and stays high for SETTLE cycles after release.
- R2: Each of `pd_pin`, `pdl_pin` and `clr_n_pin` passes through a two-stage synchronizer, followed by one more stage for edge detection. A rising edge of `pd_pin` sets `shdn` at the third clock edge after the pin changes, but only if the synchronized lockout is 1. A rising edge while the lockout is 0 is ignored, and so is a lockout that goes high while `pd_pin` is already high.
- R3: A `cmd_shdn` pulse sets `shdn` at the next clock edge if the synchronized lockout is 1. It has no effect while the lockout is 0.
- R4: Returning `pd_pin` low does not clear `shdn`. A `pd_pin` held high does not re-enter shutdown after a wake.
- R5: A falling edge of `pdl_pin` clears `shdn` at the third clock edge after the pin changes.
- R6: A falling edge of `clr_n_pin` clears `shdn` and pulses both `rv_load` and `upo_rst` for one cycle, at the third clock edge after the pin changes.
- R7: A `cmd_wake` pulse clears `shdn` at the next edge. It has no effect on any output while the block is awake. If a wake and an entry request fall in the same cycle, the wake wins.
- R8: `out_hiz` equals `shdn` in every cycle.
- R9: When `shdn` falls, `settle_busy` goes high and stays high for SETTLE cycles. SETTLE is EXT_SETTLE_CYC when USE_EXT_REF is 1 and INT_SETTLE_CYC otherwise. `ref_ready` is 1 only when the block is awake and not settling.
- R10: Entering shutdown while settling clears `settle_busy` at the same edge.
- R11: Entering or leaving shutdown by pin or command never pulses `rv_load` or `upo_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| pd_pin | input | 1 | Asynchronous power-down request, acts on its rising edge |
| pdl_pin | input | 1 | Asynchronous lockout, 1 allows power-down, falling edge wakes |
| clr_n_pin | input | 1 | Asynchronous active-low clear |
| rstval_pin | input | 1 | Static strap, 1 selects midscale as reset code |
| cmd_shdn | input | 1 | Decoded shutdown command pulse |
| cmd_wake | input | 1 | Decoded load-both or update command pulse |
| shdn | output | 1 | Shutdown flag |
| out_hiz | output | 1 | High-impedance enable for the analog output |
| rv_load | output | 1 | One-cycle strobe to load `rv_code` into both data registers |
| rv_code | output | 12 | Reset code, zero or midscale |
| upo_rst | output | 1 | One-cycle pulse returning the user output bit to its default |
| settle_busy | output | 1 | Reference settle wait in progress |
| ref_ready | output | 1 | Awake and settled |

## Verification
A behavioural model in the bench predicts every output on every clock. The stimulus covers several cases:
- A power-down edge with the lockout low and then high, which shows that gating follows the lockout level and not the edge alone.
- A held power-down level after a wake, which separates edge-triggered entry from level-triggered entry.
- Each of the three wake sources in turn. Clear is the only one that may strobe the load or the user-output reset.
- A shutdown command issued during a settle window, which checks the abort.
- A second instance built for the external reference, run on the same stimulus, which shows the parameter choosing the shorter count.
- Two resets with opposite straps, which tell the zero and midscale codes apart.

// File: rtl/dac_pwr_pkg.sv
package dac_pwr_pkg;

    // Power state of the converter core
    typedef enum logic {
        PS_AWAKE  = 1'b0,
        PS_ASLEEP = 1'b1
    } pwr_state_e;

    // Bit positions inside the synchronized pin bank
    localparam int PIN_PD   = 0;
    localparam int PIN_LOCK = 1;
    localparam int PIN_CLR  = 2;
    localparam int PIN_CNT  = 3;

    // Decoded pin events handed to the state machine
    typedef struct packed {
        logic pd_rise;
        logic lock_lvl;
        logic lock_fall;
        logic clr_hit;
    } pin_evt_t;

    function automatic int settle_len(input bit ext_ref, input int int_cyc, input int ext_cyc);
        return ext_ref ? ext_cyc : int_cyc;
    endfunction

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              last;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw[i]};
                last  <= chain[STAGES-1];
            end
        end

        assign lvl[i]  = chain[STAGES-1];
        assign prev[i] = last;
    end
endmodule

// File: rtl/dac_pwr_fsm.sv
module dac_pwr_fsm
    import dac_pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_evt_t evt,
    input  logic     cmd_shdn,
    input  logic     cmd_wake,
    output logic     asleep,
    output logic     wake_go,
    output logic     sleep_go
);
    pwr_state_e state_q, state_d;
    logic       wake_req, enter_req;

    assign wake_req  = evt.lock_fall | evt.clr_hit | cmd_wake;
    assign enter_req = evt.lock_lvl & (evt.pd_rise | cmd_shdn);

    always_comb begin
        state_d  = state_q;
        wake_go  = 1'b0;
        sleep_go = 1'b0;
        case (state_q)
            PS_AWAKE: begin
                if (enter_req && !wake_req) begin
                    state_d  = PS_ASLEEP;
                    sleep_go = 1'b1;
                end
            end
            PS_ASLEEP: begin
                if (wake_req) begin
                    state_d = PS_AWAKE;
                    wake_go = 1'b1;
                end
            end
            default: state_d = PS_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_AWAKE;
        else     state_q <= state_d;
    end

    assign asleep = (state_q == PS_ASLEEP);
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
    parameter int CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= CW'(CYCLES);
            busy <= 1'b1;
        end else if (abort) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= CW'(CYCLES);
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == CW'(1)) begin
                cnt  <= '0;
                busy <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl
    import dac_pwr_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int SYNC_STAGES    = 2,
    parameter int INT_SETTLE_CYC = 200000,
    parameter int EXT_SETTLE_CYC = 2000,
    parameter bit USE_EXT_REF    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_pin,
    input  logic              pdl_pin,
    input  logic              clr_n_pin,
    input  logic              rstval_pin,
    input  logic              cmd_shdn,
    input  logic              cmd_wake,
    output logic              shdn,
    output logic              out_hiz,
    output logic              rv_load,
    output logic [DATA_W-1:0] rv_code,
    output logic              upo_rst,
    output logic              settle_busy,
    output logic              ref_ready
);
    localparam int SETTLE = settle_len(USE_EXT_REF, INT_SETTLE_CYC, EXT_SETTLE_CYC);
    localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

    logic [PIN_CNT-1:0] raw_pins, pin_lvl, pin_prev;
    pin_evt_t           evt;
    logic               wake_go, sleep_go;
    logic               init_pend, rv_load_q, upo_q;
    logic               lock_lvl_s, lock_fall_s, clr_hit_s;

    always_comb begin
        raw_pins           = '0;
        raw_pins[PIN_PD]   = pd_pin;
        raw_pins[PIN_LOCK] = pdl_pin;
        raw_pins[PIN_CLR]  = ~clr_n_pin;
    end

    dac_pin_sync #(.N(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_pins),
        .lvl  (pin_lvl),
        .prev (pin_prev)
    );

    always_comb begin
        evt.pd_rise   = pin_lvl[PIN_PD]   & ~pin_prev[PIN_PD];
        evt.lock_lvl  = pin_lvl[PIN_LOCK];
        evt.lock_fall = ~pin_lvl[PIN_LOCK] & pin_prev[PIN_LOCK];
        evt.clr_hit   = pin_lvl[PIN_CLR]  & ~pin_prev[PIN_CLR];
    end

    assign lock_lvl_s  = evt.lock_lvl;
    assign lock_fall_s = evt.lock_fall;
    assign clr_hit_s   = evt.clr_hit;

    dac_pwr_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .cmd_shdn (cmd_shdn),
        .cmd_wake (cmd_wake),
        .asleep   (shdn),
        .wake_go  (wake_go),
        .sleep_go (sleep_go)
    );

    dac_settle_timer #(.CYCLES(SETTLE)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (wake_go),
        .abort (sleep_go),
        .busy  (settle_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            init_pend <= 1'b1;
            rv_load_q <= 1'b0;
            upo_q     <= 1'b0;
        end else begin
            init_pend <= 1'b0;
            rv_load_q <= init_pend | evt.clr_hit;
            upo_q     <= evt.clr_hit;
        end
    end

    assign rv_load   = rv_load_q;
    assign upo_rst   = upo_q;
    assign rv_code   = rstval_pin ? MID_CODE : '0;
    assign out_hiz   = shdn;
    assign ref_ready = ~shdn & ~settle_busy;
endmodule

// File: rtl/dac_pwr_chk.sv
module dac_pwr_chk (
    input logic clk,
    input logic rst,
    input logic shdn,
    input logic settle_busy,
    input logic rv_load,
    input logic upo_rst,
    input logic lock_lvl,
    input logic lock_fall,
    input logic clr_hit,
    input logic cmd_wake
);
    AST_LOCK_GATES_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn) |-> $past(lock_lvl)); // R2
    AST_EXIT_NEEDS_WAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn) |-> $past(lock_fall || clr_hit || cmd_wake)); // R4
    AST_SETTLE_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(shdn) |-> settle_busy); // R9
    AST_SETTLE_ABORT: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn) |-> !settle_busy); // R10
    AST_UPO_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        upo_rst |-> rv_load); // R6
    AST_NO_LOAD_ON_SLEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(shdn) |-> !upo_rst); // R11
endmodule

bind dac_pwr_ctrl dac_pwr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .shdn        (shdn),
    .settle_busy (settle_busy),
    .rv_load     (rv_load),
    .upo_rst     (upo_rst),
    .lock_lvl    (lock_lvl_s),
    .lock_fall   (lock_fall_s),
    .clr_hit     (clr_hit_s),
    .cmd_wake    (cmd_wake)
);

// File: tb/sim_dac_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_dac_pwr_ctrl;
    localparam int S0 = 40;
    localparam int S1 = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_pin = 1'b0, pdl_pin = 1'b0, clr_n_pin = 1'b1, rstval_pin = 1'b1;
    logic cmd_shdn = 1'b0, cmd_wake = 1'b0;

    logic        shdn, out_hiz, rv_load, upo_rst, settle_busy, ref_ready;
    logic [11:0] rv_code;
    logic        shdn1, hiz1, rvl1, upo1, busy1, rdy1;
    logic [11:0] code1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    dac_pwr_ctrl #(.INT_SETTLE_CYC(S0), .EXT_SETTLE_CYC(S1), .USE_EXT_REF(1'b0)) u0 (
        .clk(clk), .rst(rst), .pd_pin(pd_pin), .pdl_pin(pdl_pin), .clr_n_pin(clr_n_pin),
        .rstval_pin(rstval_pin), .cmd_shdn(cmd_shdn), .cmd_wake(cmd_wake),
        .shdn(shdn), .out_hiz(out_hiz), .rv_load(rv_load), .rv_code(rv_code),
        .upo_rst(upo_rst), .settle_busy(settle_busy), .ref_ready(ref_ready));

    dac_pwr_ctrl #(.INT_SETTLE_CYC(S0), .EXT_SETTLE_CYC(S1), .USE_EXT_REF(1'b1)) u1 (
        .clk(clk), .rst(rst), .pd_pin(pd_pin), .pdl_pin(pdl_pin), .clr_n_pin(clr_n_pin),
        .rstval_pin(rstval_pin), .cmd_shdn(cmd_shdn), .cmd_wake(cmd_wake),
        .shdn(shdn1), .out_hiz(hiz1), .rv_load(rvl1), .rv_code(code1),
        .upo_rst(upo1), .settle_busy(busy1), .ref_ready(rdy1));

    // Behavioural model: pin samples from past edges, flags, counters
    int p1[3], p2[3], p3[3];
    int m_shdn, m_init, m_rvl, m_upo, m_cnt0, m_cnt1;

    task automatic chk(input logic act, input int exp, input string req, input string nm);
        n_chk++;
        if (act !== exp[0]) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0d at cycle %0d", req, nm, act, exp, cyc);
        end
    endtask

    task automatic chk_code(input logic [11:0] act, input logic [11:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rv_code: actual %h expected %h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            for (int i = 0; i < 3; i++) begin p1[i] = 0; p2[i] = 0; p3[i] = 0; end
            m_shdn = 0; m_init = 1; m_rvl = 0; m_upo = 0; m_cnt0 = S0; m_cnt1 = S1;
        end else begin
            bit pd_r, lk_l, lk_f, cl_h, wake, enter;
            pd_r  = (p2[0] == 1) && (p3[0] == 0);
            lk_l  = (p2[1] == 1);
            lk_f  = (p2[1] == 0) && (p3[1] == 1);
            cl_h  = (p2[2] == 1) && (p3[2] == 0);
            wake  = lk_f || cl_h || cmd_wake;
            enter = lk_l && (pd_r || cmd_shdn);
            m_rvl = (m_init != 0 || cl_h) ? 1 : 0;
            m_upo = cl_h ? 1 : 0;
            m_init = 0;
            if (m_shdn != 0) begin
                if (wake) begin m_shdn = 0; m_cnt0 = S0; m_cnt1 = S1; end
            end else if (enter && !wake) begin
                m_shdn = 1; m_cnt0 = 0; m_cnt1 = 0;
            end else begin
                if (m_cnt0 > 0) m_cnt0--;
                if (m_cnt1 > 0) m_cnt1--;
            end
            for (int i = 0; i < 3; i++) begin p3[i] = p2[i]; p2[i] = p1[i]; end
            p1[0] = int'(pd_pin); p1[1] = int'(pdl_pin); p1[2] = int'(!clr_n_pin);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        cyc++;
        #2;
        chk(shdn, m_shdn, cur_req, "shdn");
        chk(out_hiz, m_shdn, "R8", "out_hiz");
        chk(rv_load, m_rvl, (cur_req == "R6") ? "R6" : ((cur_req == "R1") ? "R1" : "R11"), "rv_load");
        chk(upo_rst, m_upo, (cur_req == "R6") ? "R6" : "R11", "upo_rst");
        chk(settle_busy, (m_cnt0 > 0) ? 1 : 0, (cur_req == "R10") ? "R10" : "R9", "settle_busy");
        chk(ref_ready, (m_shdn == 0 && m_cnt0 == 0) ? 1 : 0, "R9", "ref_ready");
        chk(busy1, (m_cnt1 > 0) ? 1 : 0, "R9", "ext settle_busy");
        chk(shdn1, m_shdn, cur_req, "ext shdn");
        if (m_rvl != 0)
            chk_code(rv_code, rstval_pin ? 12'h800 : 12'h000, (cur_req == "R6") ? "R6" : "R1");
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_shdn();
        @(negedge clk) cmd_shdn = 1'b1;
        @(negedge clk) cmd_shdn = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) cmd_wake = 1'b1;
        @(negedge clk) cmd_wake = 1'b0;
    endtask

    initial begin
        // R1: power-up with midscale strap
        cur_req = "R1";
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(50);
        chk(shdn, 0, "R1", "shdn after power-up");
        chk(ref_ready, 1, "R1", "ref_ready after settle");

        // R2: power-down edge with lockout low is ignored
        cur_req = "R2";
        @(negedge clk) pd_pin = 1'b1;
        idle(8);
        chk(shdn, 0, "R2", "shdn with lockout low");
        @(negedge clk) pdl_pin = 1'b1;
        idle(8);
        chk(shdn, 0, "R2", "lockout rise with pd held");
        @(negedge clk) pd_pin = 1'b0;
        idle(5);
        @(negedge clk) pd_pin = 1'b1;
        idle(6);
        chk(shdn, 1, "R2", "shdn after pd edge");

        // R4: pd low does not wake
        cur_req = "R4";
        @(negedge clk) pd_pin = 1'b0;
        idle(10);
        chk(shdn, 1, "R4", "shdn after pd low");
        @(negedge clk) pd_pin = 1'b1;
        idle(6);

        // R7: command wake, pd held high must not re-enter
        cur_req = "R7";
        pulse_wake();
        idle(2);
        chk(shdn, 0, "R7", "shdn after wake command");
        cur_req = "R4";
        idle(50);
        chk(shdn, 0, "R4", "held pd does not re-enter");
        @(negedge clk) pd_pin = 1'b0;

        // R3: shutdown command
        cur_req = "R3";
        pulse_shdn();
        idle(3);
        chk(out_hiz, 1, "R8", "out_hiz in shutdown");

        // R5: lockout falling edge wakes
        cur_req = "R5";
        @(negedge clk) pdl_pin = 1'b0;
        idle(6);
        chk(shdn, 0, "R5", "shdn after lockout fall");
        idle(45);
        cur_req = "R3";
        pulse_shdn();
        idle(4);
        chk(shdn, 0, "R3", "command ignored with lockout low");

        // R6: clear wakes with zero strap
        @(negedge clk) pdl_pin = 1'b1;
        idle(4);
        cur_req = "R3";
        pulse_shdn();
        idle(3);
        @(negedge clk) rstval_pin = 1'b0;
        cur_req = "R6";
        @(negedge clk) clr_n_pin = 1'b0;
        idle(3);
        @(negedge clk) clr_n_pin = 1'b1;
        idle(6);
        chk(shdn, 0, "R6", "shdn after clear");

        // R10: shutdown during settle aborts count
        cur_req = "R10";
        pulse_shdn();
        idle(3);
        chk(settle_busy, 0, "R10", "settle aborted");
        cur_req = "R7";
        pulse_wake();
        idle(50);

        // R7: wake while awake and same-cycle conflict
        @(negedge clk) begin cmd_wake = 1'b1; cmd_shdn = 1'b1; end
        @(negedge clk) begin cmd_wake = 1'b0; cmd_shdn = 1'b0; end
        idle(4);
        chk(shdn, 0, "R7", "wake wins over entry");
        pulse_wake();
        idle(4);

        // R1: second power-up with zero strap
        cur_req = "R1";
        @(negedge clk) rst = 1'b1;
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(50);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule